// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

The block listens on one asynchronous serial input and captures complete frames into a small receive queue. The frame format is chosen at run time: five to nine data bits, an optional even or odd parity bit, and one or two stop bits on the line. A tick generator derived from the system clock and the nominal bit rate divides every bit period into four quarter-bit ticks. Each bit is sampled exactly once, near the middle of the bit.

Frames are queued exactly as they were captured, with no checking on the way in. Checking happens when the host takes a frame out through a valid/ready pop port. At that moment the block presents the data field and a status word. The status word holds separate flags for data present, an earlier lost frame, a bad start bit, a bad parity bit and a bad stop bit. When any of the three error flags is set, the captured frame is also placed in the upper half of the status word so that software can inspect it.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset `rd_valid` is 0, and `rd_data` and `rd_status` are all zero.
- R2: `rx_in` passes through a two-flop synchronizer. While the receiver is idle, a high-to-low transition of the synchronized line starts a frame. A line that is already low, or that stays low, does not start one.
- R3: A quarter-bit tick occurs every 2*(((CLK_HZ/2)/BAUD)>>2) clock cycles, counted from the start of the frame. A 2-bit phase counter, cleared at the start, advances on every tick. A bit is captured only on the tick taken while the phase is 1, which is tick 4j+2 for bit j.
- R4: The captured frame is stored LSB first. The start bit is at position 0 and data bit i is at position 1+i. The parity bit, if enabled, is at N+1, and the stop bit follows it. N is `cfg_bits`, clamped to 5..9. `cfg_parity` is coded 0 = none, 1 = even, 2 = odd, and 3 is treated as none.
- R5: A frame is 2+N bits long, plus one more bit when parity is enabled. A second stop bit on the line is never counted. The frame enters the queue on the tick that captures its first stop bit, and the receiver is idle again from the next cycle.
- R6: The queue holds DEPTH frames. `rd_valid` is high while the queue is not empty, and a frame leaves on a cycle with `rd_valid` and `rd_ready` both high. When `rd_ready` is raised on an empty queue, the status stays 0 and nothing changes.
- R7: A frame that completes while the queue is full is discarded. The next frame popped afterwards reports status bit 1 (together with bit 0), and that pop clears the indication.
- R8: `rd_data` holds the N data bits of the head frame, right-aligned, with the unused upper bits zero.
- R9: Status bit 0 is set whenever a frame is presented. Bit 2 is set when the captured start bit is 1. Bit 4 is set when the captured stop bit is 0.
- R10: Status bit 3 is set when parity is enabled and the parity bit differs from the expected value. For even parity the expected value is the XOR of the data bits, and for odd parity it is the inverse. Bit 3 is never set when parity is off.
- R11: When any of status bits 2, 3 or 4 is set, status bits 27:16 carry the 12-bit captured frame. Otherwise bits 31:16 are zero.
- R12: `fifo_clr` empties the queue on the next clock edge and clears the lost-frame indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_bits | input | 4 | Data bits per frame (5..9) |
| cfg_parity | input | 2 | Parity mode: 0 none, 1 even, 2 odd |
| fifo_clr | input | 1 | Synchronous queue clear |
| rd_valid | output | 1 | Queue holds at least one frame |
| rd_ready | input | 1 | Host takes the head frame |
| rd_data | output | 9 | Data field of the head frame |
| rd_status | output | 32 | Flags and, on error, the captured frame |

## Verification
The bench uses a 50 MHz clock with BAUD = 1,000,000. This gives a 12-cycle quarter tick and a 48-cycle bit, so the bench can predict the exact cycle of every enqueue and compare against the design on every clock. DEPTH is 2, so three back-to-back frames overflow the queue and exercise the lost-frame path within a few thousand cycles. Frames cover every data width from five to nine and all three parity modes. They also include a corrupted parity bit, a low stop bit, a start glitch shorter than half a bit, and trailing second stop bits.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_BITS  = 9;
  localparam int RAW_W     = MAX_BITS + 3;
  localparam int STAT_W    = 32;
  localparam int RAW_SHIFT = 16;
  localparam int CNT_W     = 4;

  typedef logic [RAW_W-1:0] raw_t;

  // system clocks per quarter bit: timer runs at clk/2, quarter = bit >> 2
  function automatic int qtr_clks(input int clk_hz, input int baud);
    return 2 * (((clk_hz / 2) / baud) >> 2);
  endfunction

  function automatic logic [CNT_W-1:0] eff_bits(input logic [3:0] b);
    if (b < 4'd5) return 4'd5;
    if (b > 4'd9) return 4'd9;
    return b;
  endfunction

  function automatic logic par_en(input logic [1:0] p);
    return (p == 2'd1) || (p == 2'd2);
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic [CNT_W-1:0] n, input logic [1:0] p);
    return n + 4'd2 + {3'b000, par_en(p)};
  endfunction

  function automatic logic [MAX_BITS-1:0] raw_data(input raw_t raw, input logic [CNT_W-1:0] n);
    logic [MAX_BITS-1:0] d;
    for (int i = 0; i < MAX_BITS; i++) d[i] = (i < int'(n)) ? raw[i+1] : 1'b0;
    return d;
  endfunction

  function automatic logic [STAT_W-1:0] raw_status(input raw_t raw, input logic [CNT_W-1:0] n,
                                                   input logic [1:0] p, input logic lost);
    logic [STAT_W-1:0] s;
    logic x;
    int sp;
    x = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) if (i < int'(n)) x = x ^ raw[i+1];
    if (p == 2'd2) x = ~x;
    sp = int'(n) + 1 + int'(par_en(p));
    s = '0;
    s[0] = 1'b1;
    s[1] = lost;
    s[2] = raw[0];
    s[3] = par_en(p) && (raw[int'(n)+1] != x);
    s[4] = ~raw[sp];
    if (|s[4:2]) s[RAW_SHIFT +: RAW_W] = raw;
    return s;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= 3'b111;
    else        sh <= {sh[1:0], din};
  end

  assign line = sh[1];
  assign fall = sh[2] & ~sh[1];
endmodule

// File: rtl/srx_qtick.sv
module srx_qtick #(
  parameter int QTR = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(QTR + 1);
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(QTR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srx_framer.sv
module srx_framer import srx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             fall,
  input  logic             tick,
  input  logic [CNT_W-1:0] nbits,
  input  logic [1:0]       par,
  output logic             busy,
  output logic             done,
  output raw_t             raw_now
);
  logic [CNT_W-1:0] bitcnt;
  logic [CNT_W-1:0] flen;
  logic [1:0]       phase;
  logic             sample;
  logic             last_bit;
  raw_t             raw;

  assign flen     = frame_len(nbits, par);
  assign last_bit = (bitcnt == flen - 1'b1);
  assign sample   = busy && tick && (phase == 2'd1);
  assign done     = sample && last_bit;
  assign raw_now  = raw | (raw_t'(line) << bitcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 2'd0; bitcnt <= '0; raw <= '0;
    end else if (!busy) begin
      if (fall) begin
        busy <= 1'b1; phase <= 2'd0; bitcnt <= '0; raw <= '0;
      end
    end else if (tick) begin
      phase <= phase + 2'd1;
      if (phase == 2'd1) begin
        raw    <= raw_now;
        bitcnt <= bitcnt + 1'b1;
        if (last_bit) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo import srx_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  raw_t                       din,
  input  logic                       pop,
  output raw_t                       dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  raw_t          mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx import srx_pkg::*; #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_in,
  input  logic [3:0]          cfg_bits,
  input  logic [1:0]          cfg_parity,
  input  logic                fifo_clr,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [MAX_BITS-1:0] rd_data,
  output logic [STAT_W-1:0]   rd_status
);
  localparam int QTR = qtr_clks(CLK_HZ, BAUD);
  localparam int CW  = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  logic             line_s, fall, tick, busy, frame_done;
  logic             fifo_full, fifo_empty, rd_fire, drop, lost;
  logic [CW-1:0]    fifo_count;
  logic [CNT_W-1:0] n_eff;
  raw_t             raw_now, head;

  assign n_eff = eff_bits(cfg_bits);

  srx_sync u_sync (.clk(clk), .rst_n(rst_n), .din(rx_in), .line(line_s), .fall(fall));

  srx_qtick #(.QTR(QTR)) u_tick (.clk(clk), .rst_n(rst_n), .en(busy), .tick(tick));

  srx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .line(line_s), .fall(fall), .tick(tick),
    .nbits(n_eff), .par(cfg_parity), .busy(busy), .done(frame_done), .raw_now(raw_now)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(frame_done), .din(raw_now),
    .pop(rd_ready), .dout(head), .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
  );

  assign rd_valid = !fifo_empty;
  assign rd_fire  = rd_valid && rd_ready;
  assign drop     = frame_done && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lost <= 1'b0;
    else if (fifo_clr) lost <= 1'b0;
    else               lost <= (lost && !rd_fire) || drop;
  end

  assign rd_data   = rd_valid ? raw_data(head, n_eff) : '0;
  assign rd_status = rd_valid ? raw_status(head, n_eff, cfg_parity, lost) : '0;
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fifo_clr,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [31:0]                rd_status,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       fifo_full,
  input logic                       frame_done,
  input logic                       busy,
  input logic                       tick,
  input logic                       drop,
  input logic                       lost
);
  localparam int CW = $clog2(DEPTH + 1);

  // R1
  empty_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_status == 32'd0);

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  // R6
  empty_pop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid && !frame_done && !fifo_clr) |=> $stable(fifo_count));

  // R6
  push_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !fifo_full && !(rd_ready && rd_valid) && !fifo_clr)
      |=> fifo_count == $past(fifo_count) + CW'(1));

  // R7
  drop_marks_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !fifo_clr) |=> lost);

  // R9
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_status[0]);

  // R11
  clean_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status[4:2] == 3'b000) |-> rd_status[31:16] == 16'd0);

  // R12
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fifo_count == '0) && !lost);
endmodule

bind serial_frame_rx srx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_status(rd_status), .fifo_count(fifo_count), .fifo_full(fifo_full),
  .frame_done(frame_done), .busy(busy), .tick(tick), .drop(drop), .lost(lost)
);

// File: tb/serial_frame_rx_tb.sv
`timescale 1ns/1ps
module serial_frame_rx_tb;
  localparam int CLK_HZ    = 50_000_000;
  localparam int BAUD      = 1_000_000;
  localparam int DEPTH     = 2;
  localparam int BIT_TIMER = (CLK_HZ / 2) / BAUD;
  localparam int QCLK      = (BIT_TIMER / 4) * 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic [3:0]  cfg_bits = 4'd8;
  logic [1:0]  cfg_parity = 2'd0;
  logic        fifo_clr = 1'b0;
  logic        rd_ready = 1'b0;
  logic        rd_valid;
  logic [8:0]  rd_data;
  logic [31:0] rd_status;

  always #10 clk = ~clk;

  serial_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_line), .cfg_bits(cfg_bits), .cfg_parity(cfg_parity),
    .fifo_clr(fifo_clr), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_status(rd_status)
  );

  int    checks = 0, errors = 0, cyc = 0, sched = -1;
  string tag = "R1";
  bit    live = 0, pop_seen = 0, clr_seen = 0, m_lost = 0;
  logic [11:0] sched_raw;
  logic [11:0] mq[$];

  function automatic logic [31:0] ref_status(logic [11:0] r, int n, int par, bit lst);
    logic [31:0] s = 32'd1;
    int pos = n + 1;
    bit p = 0;
    if (lst) s |= 32'd2;
    if (r[0]) s |= 32'd4;
    if (par == 1 || par == 2) begin
      for (int i = 1; i <= n; i++) p ^= r[i];
      if (par == 2) p = !p;
      if (r[n+1] != p) s |= 32'd8;
      pos++;
    end
    if (!r[pos]) s |= 32'd16;
    if ((s & 32'd28) != 0) s |= {4'd0, r, 16'd0};
    return s;
  endfunction

  function automatic logic [8:0] ref_data(logic [11:0] r, int n);
    return 9'((r >> 1) & ((12'd1 << n) - 1));
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    pop_seen <= rd_ready;
    clr_seen <= fifo_clr;
  end

  // behavioural reference, compared every clock
  always @(negedge clk) begin : model
    bit fb;
    if (live) begin
      if (clr_seen) begin
        mq.delete(); m_lost = 0;
      end else begin
        fb = (mq.size() == DEPTH);
        if (pop_seen && mq.size() > 0) begin void'(mq.pop_front()); m_lost = 0; end
        if (cyc == sched) begin
          if (fb) m_lost = 1; else mq.push_back(sched_raw);
        end
      end
      check(rd_valid === (mq.size() > 0), tag, "rd_valid", rd_valid, mq.size() > 0);
      if (mq.size() > 0) begin
        check(rd_data === ref_data(mq[0], cfg_bits), tag, "rd_data", rd_data,
              ref_data(mq[0], cfg_bits));
        check(rd_status === ref_status(mq[0], cfg_bits, cfg_parity, m_lost), tag, "rd_status",
              rd_status, ref_status(mq[0], cfg_bits, cfg_parity, m_lost));
      end
    end
  end

  task automatic send(int n, int par, int val, bit flip, bit bad_stop, bit two_stop);
    logic [15:0] seq = '0;
    int k, len, t0;
    bit pb = 0;
    @(negedge clk);
    cfg_bits = 4'(n); cfg_parity = 2'(par);
    for (int i = 0; i < n; i++) begin seq[1+i] = val[i]; pb ^= val[i]; end
    k = 1 + n;
    if (par != 0) begin
      if (par == 2) pb = !pb;
      seq[k] = pb ^ flip; k++;
    end
    seq[k] = !bad_stop;
    len = k + 1;
    if (two_stop) seq[k+1] = 1'b1;
    repeat (3) @(negedge clk);
    t0 = cyc;
    sched_raw = 12'(seq & ((16'd1 << len) - 1));
    sched = t0 + 3 + (4 * (len - 1) + 2) * QCLK;
    for (int b = 0; b < len + two_stop; b++) begin
      rx_line = seq[b];
      repeat (4 * QCLK) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic glitch(int n, int par);
    int len, t0;
    @(negedge clk);
    cfg_bits = 4'(n); cfg_parity = 2'(par);
    repeat (3) @(negedge clk);
    len = 2 + n + ((par != 0) ? 1 : 0);
    t0 = cyc;
    sched_raw = 12'((1 << len) - 1);
    sched = t0 + 3 + (4 * (len - 1) + 2) * QCLK;
    rx_line = 1'b0;
    repeat (QCLK) @(negedge clk);
    rx_line = 1'b1;
    repeat (4 * QCLK * len + 4) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic drain();
    while (rd_valid) pop_one();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
    check(rd_status == 0 && rd_data == 0, "R1", "rd_status", rd_status, 0);
    live = 1;

    tag = "R2";  send(8, 0, 'hA5, 0, 0, 0); drain();
    tag = "R3";  send(8, 0, 'h3C, 0, 0, 0); drain();
    tag = "R4";  send(9, 0, 'h1C3, 0, 0, 1); drain();
    tag = "R5";  send(6, 1, 'h2A, 0, 0, 1); send(6, 1, 'h15, 0, 0, 0); drain();
    tag = "R8";  send(5, 2, 'h0B, 0, 0, 0); drain();
    tag = "R10"; send(7, 1, 'h35, 0, 0, 0); drain();
    send(8, 2, 'h00, 0, 0, 0); drain();
    send(8, 1, 'h5C, 1, 0, 0); drain();
    send(9, 2, 'h0F1, 1, 0, 0); drain();
    tag = "R9";  send(8, 0, 'h7E, 0, 1, 0);
    repeat (400) @(negedge clk);
    check(rd_valid == 1 && rd_status[4] == 1, "R9", "bad stop flag", rd_status, 'h10);
    drain();
    // R2: line held low after a bad stop must not have started a frame
    check(rd_valid == 0, "R2", "no spurious frame", rd_valid, 0);
    glitch(8, 2);
    check(rd_status[2] == 1, "R9", "bad start flag", rd_status, 'h4);
    tag = "R11"; drain();

    tag = "R6";
    pop_one(); pop_one();
    check(rd_valid == 0 && rd_status == 0, "R6", "pop on empty", rd_status, 0);
    send(8, 0, 'h66, 0, 0, 0);
    check(rd_data == 9'h66, "R6", "first after empty pop", rd_data, 'h66);
    drain();

    tag = "R7";
    send(8, 0, 'h11, 0, 0, 0); send(8, 0, 'h22, 0, 0, 0); send(8, 0, 'h33, 0, 0, 0);
    check(rd_status[1:0] == 2'b11, "R7", "lost flag", rd_status[1:0], 3);
    check(rd_data == 9'h11, "R7", "head kept", rd_data, 'h11);
    pop_one(); @(negedge clk);
    check(rd_status[1] == 0 && rd_data == 9'h22, "R7", "lost cleared", rd_status, 1);
    drain();

    tag = "R12";
    send(8, 0, 'h44, 0, 0, 0); send(8, 0, 'h55, 0, 0, 0); send(8, 0, 'h77, 0, 0, 0);
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
    @(negedge clk);
    check(rd_valid == 0, "R12", "cleared", rd_valid, 0);
    send(8, 0, 'h12, 0, 0, 0);
    check(rd_status == 32'd1, "R12", "lost cleared", rd_status, 1);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule